// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is the byte-level command engine of an I2C target that fronts a 32K x 8 nonvolatile memory. A bit-level layer beneath it handles SCL/SDA sampling and filtering and hands up one-cycle event pulses: a start (or repeated start) condition, a stop condition, a fully received byte, and the master's acknowledge bit after each byte the target sent. The engine answers each received byte with an acknowledge decision, and supplies the next read byte each time one is due.

The engine decodes the device select byte and the two-byte word address. It keeps one address counter that survives across transactions. It drives single-cycle write strobes toward a separate programming store and reads that store through a combinational read port. It supports byte and page writes, current-address reads, random reads through a header-only write, and sequential reads. While the store reports a write cycle in progress, the engine refuses its select byte, so a host can poll for completion. A write-protect input blocks the write strobes.

Top module: `i2c_eeprom_target`

## Requirements
- R1: During and right after reset, `ack_valid`, `tx_valid` and `wr_en` are low and the address counter, seen on `rd_addr`, is 0.
- R2: The first byte after a start is a select byte whose bits [7:1] are the device address (default 7'h50) and whose bit 0 is 1 for a read and 0 for a write. One cycle later `ack_valid` pulses, with `ack_bit` = 1 when bits [7:1] match and `ack_bit` = 0 when they do not. After a mismatch, no further byte gets an `ack_valid` pulse until the next start.
- R3: When `wr_busy` is high as a select byte arrives, that byte is answered with `ack_bit` = 0 and later bytes get no `ack_valid` until the next start. The same select byte is acknowledged once `wr_busy` is low again.
- R4: After a write select, the next two bytes are the word address, high byte first. Each is acknowledged. The counter loads {high[6:0], low}, and bit 7 of the high byte is ignored.
- R5: Every later byte of a write is acknowledged, and it raises `wr_en` for one cycle with `wr_addr` = counter and `wr_data` = that byte. The counter then steps in its low 6 bits only, wrapping inside its 64-byte page while bits [14:6] stay fixed.
- R6: While `wp` is high, write data bytes are still acknowledged and still advance the counter, but `wr_en` stays low.
- R7: A read select that is acknowledged puts the byte at the counter onto `tx_byte` with a one-cycle `tx_valid`, in the same cycle as its `ack_valid`. Each master ACK (`mst_nack` = 0) sends the byte at the next address. The counter steps over all 15 bits, so 32767 is followed by 0.
- R8: A master NACK (`mst_nack` = 1) ends the read. No further `tx_valid` occurs, even on later master ACK events, until a new start.
- R9: The counter keeps its value across stop conditions. A current-address read returns the byte after the last byte accessed, and address 0 when that last byte was at 32767.
- R10: A start or stop pulse in the same cycle as `rx_valid` or `mst_ack_valid` wins. The byte or ACK event is dropped, and the next cycle has no `ack_valid`, `tx_valid` or `wr_en`.
- R11: A write select with two address bytes and no data, followed by a repeated start and a read select, returns the byte at the address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated start seen (pulse) |
| bus_stop | input | 1 | Stop seen (pulse) |
| rx_valid | input | 1 | A byte from the master is complete (pulse) |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| mst_ack_valid | input | 1 | Master acknowledge bit after a read byte (pulse) |
| mst_nack | input | 1 | 1 = master NACK, 0 = master ACK |
| wp | input | 1 | Write protect |
| wr_busy | input | 1 | Internal write cycle in progress |
| ack_valid | output | 1 | Acknowledge decision for the last received byte (pulse) |
| ack_bit | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid | output | 1 | Next read byte ready (pulse) |
| tx_byte | output | 8 | Read byte for the bit layer |
| rd_addr | output | 15 | Address counter, used as the store read address |
| rd_data | input | 8 | Combinational store data at `rd_addr` |
| wr_en | output | 1 | Write strobe to the store |
| wr_addr | output | 15 | Write address |
| wr_data | output | 8 | Write data |

## Verification
Bus conditions and byte events can land in the same clock cycle. A start or stop arriving together with a received byte must override the byte rather than let it be acknowledged or written. The bench provokes this by raising `bus_start` or `bus_stop` in the same cycle as `rx_valid`. It judges the outcome from the missing `ack_valid`, `tx_valid` and `wr_en` pulses. It also checks that the engine then still accepts a clean select byte, which shows the state left behind. A second overlap, `wr_busy` high at the moment a select byte lands, is judged by the refused acknowledge, and by a normal acknowledge once busy clears.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start condition
      ST_SEL,    // expecting the select byte
      ST_AHI,    // expecting word address, high byte
      ST_ALO,    // expecting word address, low byte
      ST_WR,     // write data phase
      ST_RD,     // read data phase
      ST_SKIP    // ignore everything until the next start
   } i2ce_st_e;
endpackage

// File: rtl/i2ce_sel_match.sv
module i2ce_sel_match #(
   parameter logic [6:0] DEV_ADDR = 7'h50
) (
   input  logic [7:0] sel_byte,
   output logic       hit,
   output logic       is_rd
);
   assign hit   = (sel_byte[7:1] == DEV_ADDR);
   assign is_rd = sel_byte[0];
endmodule

// File: rtl/i2ce_addr_ctr.sv
module i2ce_addr_ctr #(
   parameter int ADDR_W    = 15,
   parameter int PAGE_BITS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              step_full,
   input  logic              step_page,
   output logic [ADDR_W-1:0] cnt
);
   localparam logic [ADDR_W-1:0] ONE = 1;
   logic [ADDR_W-1:0] page_nxt;

   generate
      if (PAGE_BITS == 0) begin : g_flat
         assign page_nxt = cnt + ONE;
      end else begin : g_page
         localparam logic [PAGE_BITS-1:0] PONE = 1;
         assign page_nxt = {cnt[ADDR_W-1:PAGE_BITS], cnt[PAGE_BITS-1:0] + PONE};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (ld_en)     cnt <= ld_val;
      else if (step_full) cnt <= cnt + ONE;
      else if (step_page) cnt <= page_nxt;
   end
endmodule

// File: rtl/i2ce_ctl.sv
module i2ce_ctl
   import i2ce_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              mst_ack_valid,
   input  logic              mst_nack,
   input  logic              wp,
   input  logic              wr_busy,
   input  logic              sel_hit,
   input  logic              sel_rd,
   input  logic [ADDR_W-1:0] cnt,
   input  logic [7:0]        rd_data,
   output logic              ack_valid,
   output logic              ack_bit,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              ld_en,
   output logic [ADDR_W-1:0] ld_val,
   output logic              step_full,
   output logic              step_page,
   output i2ce_st_e          st
);
   localparam int HI_W = ADDR_W - 8;

   logic            byte_ev, mack_ev, sel_ok, acks_bytes;
   logic [HI_W-1:0] hi_q;

   always_comb begin
      byte_ev    = rx_valid & ~bus_start & ~bus_stop;
      mack_ev    = mst_ack_valid & ~bus_start & ~bus_stop;
      sel_ok     = sel_hit & ~wr_busy;
      acks_bytes = (st == ST_SEL) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WR);
      ld_en      = byte_ev && (st == ST_ALO);
      ld_val     = {hi_q, rx_byte};
      step_full  = (byte_ev && (st == ST_SEL) && sel_ok && sel_rd) ||
                   (mack_ev && (st == ST_RD) && !mst_nack);
      step_page  = byte_ev && (st == ST_WR);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
      end else if (bus_start) begin
         st <= ST_SEL;
      end else if (bus_stop) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_SEL: if (byte_ev) st <= !sel_ok ? ST_SKIP : (sel_rd ? ST_RD : ST_AHI);
            ST_AHI: if (byte_ev) st <= ST_ALO;
            ST_ALO: if (byte_ev) st <= ST_WR;
            ST_RD:  if (mack_ev && mst_nack) st <= ST_SKIP;
            default: st <= st;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_bit   <= 1'b0;
         tx_valid  <= 1'b0;
         tx_byte   <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         hi_q      <= '0;
      end else begin
         ack_valid <= byte_ev && acks_bytes;
         ack_bit   <= (st == ST_SEL) ? sel_ok : 1'b1;
         tx_valid  <= step_full;
         wr_en     <= step_page && !wp;
         if (step_full) tx_byte <= rd_data;
         if (step_page) begin
            wr_addr <= cnt;
            wr_data <= rx_byte;
         end
         if (byte_ev && (st == ST_AHI)) hi_q <= rx_byte[HI_W-1:0];
      end
   end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import i2ce_pkg::*;
#(
   parameter int         ADDR_W    = 15,
   parameter int         PAGE_BITS = 6,
   parameter logic [6:0] DEV_ADDR  = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              mst_ack_valid,
   input  logic              mst_nack,
   input  logic              wp,
   input  logic              wr_busy,
   output logic              ack_valid,
   output logic              ack_bit,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must fit two address bytes with at least 9 bits");
      end
      if (PAGE_BITS < 0 || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("PAGE_BITS must lie in [0, ADDR_W)");
      end
   endgenerate

   logic              sel_hit, sel_rd, ld_en, step_full, step_page;
   logic [ADDR_W-1:0] ld_val, cnt;
   i2ce_st_e          st;

   i2ce_sel_match #(.DEV_ADDR(DEV_ADDR)) u_sel (
      .sel_byte(rx_byte), .hit(sel_hit), .is_rd(sel_rd)
   );

   i2ce_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
      .step_full(step_full), .step_page(step_page), .cnt(cnt)
   );

   i2ce_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .mst_ack_valid(mst_ack_valid),
      .mst_nack(mst_nack), .wp(wp), .wr_busy(wr_busy), .sel_hit(sel_hit),
      .sel_rd(sel_rd), .cnt(cnt), .rd_data(rd_data), .ack_valid(ack_valid),
      .ack_bit(ack_bit), .tx_valid(tx_valid), .tx_byte(tx_byte), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ld_en(ld_en), .ld_val(ld_val),
      .step_full(step_full), .step_page(step_page), .st(st)
   );

   assign rd_addr = cnt;
endmodule

// File: rtl/i2ce_chk.sv
module i2ce_chk
   import i2ce_pkg::*;
#(
   parameter int         ADDR_W    = 15,
   parameter int         PAGE_BITS = 6,
   parameter logic [6:0] DEV_ADDR  = 7'h50
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_start,
   input logic              bus_stop,
   input logic              rx_valid,
   input logic [7:0]        rx_byte,
   input logic              wp,
   input logic              wr_busy,
   input logic              ack_valid,
   input logic              ack_bit,
   input logic              tx_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input i2ce_st_e          st
);
   localparam logic [ADDR_W-1:0] ONE = 1;

   assert_sel_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEL && rx_valid && !bus_start && !bus_stop && !wr_busy)
      |=> (ack_valid && (ack_bit == ($past(rx_byte[7:1]) == DEV_ADDR))));

   assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEL && rx_valid && !bus_start && !bus_stop && wr_busy)
      |=> (ack_valid && !ack_bit));

   assert_wp_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && wp) |=> !wr_en);

   assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (rd_addr == $past(rd_addr) + ONE));

   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start || bus_stop) |=> (!ack_valid && !tx_valid && !wr_en));

   generate
      if (PAGE_BITS > 0) begin : g_page_chk
         assert_wr_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> ((rd_addr >> PAGE_BITS) == (wr_addr >> PAGE_BITS)) &&
                      (rd_addr != wr_addr));
      end
   endgenerate
endmodule

bind i2c_eeprom_target i2ce_chk #(
   .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DEV_ADDR(DEV_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
   .rx_valid(rx_valid), .rx_byte(rx_byte), .wp(wp), .wr_busy(wr_busy),
   .ack_valid(ack_valid), .ack_bit(ack_bit), .tx_valid(tx_valid),
   .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .st(st)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        mst_ack_valid = 1'b0, mst_nack = 1'b0, wp = 1'b0, wr_busy = 1'b0;
   logic        ack_valid, ack_bit, tx_valid, wr_en;
   logic [7:0]  tx_byte, rd_data, wr_data;
   logic [14:0] rd_addr, wr_addr;

   int vectors = 0;
   int errors  = 0;
   int exp_cnt = 0;

   always #4 clk = ~clk;   // 125 MHz

   function automatic logic [7:0] mem_f(input int a);
      return 8'((a * 37) ^ (a >> 7));
   endfunction

   assign rd_data = mem_f(int'(rd_addr));

   i2c_eeprom_target uut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .mst_ack_valid(mst_ack_valid),
      .mst_nack(mst_nack), .wp(wp), .wr_busy(wr_busy), .ack_valid(ack_valid),
      .ack_bit(ack_bit), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic do_start();
      @(negedge clk) bus_start = 1'b1;
      @(negedge clk) bus_start = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk) bus_stop = 1'b1;
      @(negedge clk) bus_stop = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
      @(negedge clk) rx_valid = 1'b0;
   endtask

   task automatic mack(input logic n);
      @(negedge clk) begin mst_ack_valid = 1'b1; mst_nack = n; end
      @(negedge clk) mst_ack_valid = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   // read select accepted, expect data at exp_cnt
   task automatic rd_select(input string req);
      send(8'hA1);
      chk_eq({req, " ack"}, int'(ack_valid && ack_bit), 1);
      chk_eq({req, " tx_valid"}, int'(tx_valid), 1);
      chk_eq({req, " tx_byte"}, int'(tx_byte), int'(mem_f(exp_cnt)));
      exp_cnt = (exp_cnt + 1) % 32768;
   endtask

   task automatic set_addr(input int a, input logic [7:0] hi_extra);
      do_start();
      send(8'hA0);
      send(8'((a >> 8) & 8'h7F) | hi_extra);
      chk_eq("R4 high byte ack", int'(ack_valid && ack_bit), 1);
      send(8'(a & 8'hFF));
      chk_eq("R4 low byte ack", int'(ack_valid && ack_bit), 1);
      chk_eq("R4 counter load", int'(rd_addr), a);
      exp_cnt = a;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk_eq("R1 ack_valid", int'(ack_valid), 0);
      chk_eq("R1 tx_valid", int'(tx_valid), 0);
      chk_eq("R1 wr_en", int'(wr_en), 0);
      chk_eq("R1 counter", int'(rd_addr), 0);
      rst_n = 1'b1;

      // R2 exhaustive select sweep
      for (int b = 0; b < 256; b++) begin
         do_start();
         if (b == 8'hA1) begin
            rd_select("R2 read select");
         end else begin
            send(8'(b));
            chk_eq("R2 ack_valid", int'(ack_valid), 1);
            chk_eq("R2 ack_bit", int'(ack_bit), int'(b[7:1] == 7'h50));
            if (b[7:1] != 7'h50) begin
               send(8'h55);
               chk_eq("R2 ignore after mismatch", int'(ack_valid), 0);
            end
         end
         do_stop();
      end

      // R4 R5 page write with high bit set and page wrap
      set_addr(32'h7FF8, 8'h80);
      for (int i = 0; i < 70; i++) begin
         send(8'(i * 3 + 1));
         chk_eq("R5 data ack", int'(ack_valid && ack_bit), 1);
         chk_eq("R5 wr_en", int'(wr_en), 1);
         chk_eq("R5 wr_addr", int'(wr_addr), 32'h7FC0 | ((32'h38 + i) & 63));
         chk_eq("R5 wr_data", int'(wr_data), (i * 3 + 1) & 255);
      end
      exp_cnt = 32'h7FC0 | ((32'h38 + 70) & 63);
      chk_eq("R5 counter after wrap", int'(rd_addr), exp_cnt);
      do_stop();

      // R9 current read continues after stop
      do_start();
      rd_select("R9 current read");
      mack(1'b1);
      do_stop();

      // R6 write protect
      wp = 1'b1;
      set_addr(32'h0123, 8'h00);
      for (int i = 0; i < 3; i++) begin
         send(8'hC3);
         chk_eq("R6 ack", int'(ack_valid && ack_bit), 1);
         chk_eq("R6 wr_en low", int'(wr_en), 0);
      end
      chk_eq("R6 counter advanced", int'(rd_addr), 32'h0126);
      do_stop();
      wp = 1'b0;

      // R3 busy refusal then ack polling
      wr_busy = 1'b1;
      do_start();
      send(8'hA0);
      chk_eq("R3 select refused", int'(ack_valid && !ack_bit), 1);
      send(8'h00);
      chk_eq("R3 ignore after refusal", int'(ack_valid), 0);
      do_stop();
      wr_busy = 1'b0;
      do_start();
      send(8'hA0);
      chk_eq("R3 accepted when idle", int'(ack_valid && ack_bit), 1);
      do_stop();

      // R11 R7 R8 random reads then sequential steps
      for (int i = 0; i < 40; i++) begin
         int a;
         a = (i == 0) ? 32766 : (i * 829 + 17) % 32768;
         set_addr(a, 8'h00);
         do_start();
         rd_select("R11 random read");
         for (int k = 0; k < 3; k++) begin
            mack(1'b0);
            chk_eq("R7 seq tx_valid", int'(tx_valid), 1);
            chk_eq("R7 seq tx_byte", int'(tx_byte), int'(mem_f(exp_cnt)));
            exp_cnt = (exp_cnt + 1) % 32768;
         end
         mack(1'b1);
         chk_eq("R8 nack stops", int'(tx_valid), 0);
         mack(1'b0);
         chk_eq("R8 no data after nack", int'(tx_valid), 0);
         do_stop();
      end

      // R9 last access 32767 -> current read from 0
      set_addr(32767, 8'h00);
      do_start();
      rd_select("R9 read at top");
      mack(1'b1);
      do_stop();
      do_start();
      chk_eq("R9 wrapped counter", exp_cnt, 0);
      rd_select("R9 current read after wrap");
      mack(1'b1);
      do_stop();

      // R10 start coinciding with byte
      do_start();
      @(negedge clk) begin bus_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'hA1; end
      @(negedge clk) begin bus_start = 1'b0; rx_valid = 1'b0; end
      chk_eq("R10 start wins ack", int'(ack_valid), 0);
      chk_eq("R10 start wins tx", int'(tx_valid), 0);
      rd_select("R10 clean select after collision");
      do_stop();

      // R10 stop coinciding with write data
      set_addr(32'h0200, 8'h00);
      @(negedge clk) begin bus_stop = 1'b1; rx_valid = 1'b1; rx_byte = 8'h77; end
      @(negedge clk) begin bus_stop = 1'b0; rx_valid = 1'b0; end
      chk_eq("R10 stop wins wr_en", int'(wr_en), 0);
      chk_eq("R10 stop wins ack", int'(ack_valid), 0);
      chk_eq("R10 counter unchanged", int'(rd_addr), 32'h0200);

      repeat (2) @(negedge clk);
      summary();
   end
endmodule